// File: doc/BRIEF.md
# Pseudo-Random Pattern Checker with Error Counter

This block takes a serial bit stream qualified by a per-bit valid strobe and compares it against one of two maximal-length pseudo-random sequences. It needs no seed. In the hunting phase it fills its shift register straight from the line. Once it has seen enough bits in a row that its own prediction matches, it declares lock. From then on its reference runs freely from its own predictions. Each differing bit counts as one bit error.

The error count is 8 bits wide and stops at 255. A one-cycle clear pulse returns it to zero. A register wrapper can present that pulse as a write-one bit that clears itself. The sync flag reads 0 whenever the checker is disabled. If the error density gets too high while locked, the checker gives up lock and hunts again. Changing the length select while enabled also restarts the hunt.

Top module: `prbs_err_checker`

## Requirements
- R1: While `det_en_i` is 0, `sync_o` is 0 from the following cycle onward, bits are not counted, the count holds its value, and the hunt restarts from an empty fill when the enable returns.
- R2: After enabling on a clean stream, the first L valid bits only load the shift register. `sync_o` rises in the cycle after the 32nd consecutive matching bit that follows, which is after exactly L+32 valid bits.
- R3: With `seq15_sel_i` = 1, L = 15 and the sequence obeys b[n] = b[n-15] XOR b[n-14]. With `seq15_sel_i` = 0, L = 20 and b[n] = b[n-20] XOR b[n-17].
- R4: While hunting, a mismatch restarts the run of 32 matches, and the mismatching bit still enters the shift register. Mismatches while hunting never change the error count.
- R5: While locked, each valid bit that differs from the reference raises `err_cnt_o` by exactly one, visible in the cycle after that bit.
- R6: The count saturates at 255. Further errors leave it at 255.
- R7: A `clr_cnt_i` pulse sets the count to 0 in the next cycle, even if an error arrives in the same cycle.
- R8: While locked, the checker drops `sync_o` in the cycle after the bit that brings the errors within the last 64 valid bits to 6, and that bit is still counted. Five errors inside 64 bits keep the lock. After a drop, relock takes L+32 clean bits.
- R9: A cycle with `bit_vld_i` = 0 changes neither the lock state nor the count, apart from a clear.
- R10: A change of `seq15_sel_i` while enabled drops `sync_o` in the next cycle and restarts the hunt.
- R11: After reset, `sync_o` is 0 and `err_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | Checker enable |
| seq15_sel_i | input | 1 | 1: 2^15-1 sequence, 0: 2^20-1 sequence |
| clr_cnt_i | input | 1 | One-cycle pulse that zeroes the error count |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Received serial data bit |
| sync_o | output | 1 | Locked to the incoming sequence |
| err_cnt_o | output | 8 | Saturating bit-error count |

## Verification
The assertions check the cycle-level rules on every cycle:
- the count moves by at most one per cycle;
- it never moves while unlocked or when no valid bit arrives;
- it stays at 255 and zeroes after a clear;
- sync is off when disabled or after a mode change.

Only the bench scenarios can show the sequence-dependent behaviour:
- lock after exactly L+32 bits in each mode;
- the delayed lock after a hunting error;
- the five-versus-six error boundary of the 64-bit window;
- the relock that follows a drop.

// File: rtl/prbs_err_checker.sv
module prbs_err_checker #(
  parameter int CNT_W     = 8,
  parameter int SHORT_LEN = 15,
  parameter int SHORT_TAP = 14,
  parameter int LONG_LEN  = 20,
  parameter int LONG_TAP  = 17,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_en_i,
  input  logic             seq15_sel_i,
  input  logic             clr_cnt_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] err_cnt_o
);

  localparam int SR_W   = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int FILL_W = $clog2(SR_W + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [FILL_W-1:0] FILL_S   = FILL_W'(SHORT_LEN);
  localparam logic [FILL_W-1:0] FILL_L   = FILL_W'(LONG_LEN);
  localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIN_W-1:0]  WIN_LIM  = WIN_W'(LOSS_ERRS);

  logic [SR_W-1:0]    sr_q;
  logic [FILL_W-1:0]  fill_q;
  logic [RUN_W-1:0]   run_q;
  logic [WIN_LEN-1:0] hist_q;
  logic [WIN_W-1:0]   win_q, win_nxt;
  logic [CNT_W-1:0]   cnt_q;
  logic               sync_q, mode_q;
  logic               pred, mism, restart, filled, lose;

  // reference prediction from the selected taps
  assign pred    = seq15_sel_i ? (sr_q[SHORT_LEN-1] ^ sr_q[SHORT_TAP-1])
                               : (sr_q[LONG_LEN-1]  ^ sr_q[LONG_TAP-1]);
  assign mism    = bit_i ^ pred;
  assign restart = !det_en_i || (seq15_sel_i != mode_q);
  assign filled  = (fill_q == (seq15_sel_i ? FILL_S : FILL_L));
  assign win_nxt = win_q + WIN_W'(mism) - WIN_W'(hist_q[WIN_LEN-1]);
  assign lose    = (win_nxt >= WIN_LIM);

  assign sync_o    = sync_q;
  assign err_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      fill_q <= '0;
      run_q  <= '0;
      hist_q <= '0;
      win_q  <= '0;
      sync_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= seq15_sel_i;
      if (restart) begin
        sync_q <= 1'b0;
        fill_q <= '0;
        run_q  <= '0;
        hist_q <= '0;
        win_q  <= '0;
      end else if (bit_vld_i) begin
        if (!sync_q) begin
          sr_q <= {sr_q[SR_W-2:0], bit_i};
          if (!filled) begin
            fill_q <= fill_q + 1'b1;
            run_q  <= '0;
          end else if (mism) begin
            run_q <= '0;
          end else if (run_q == RUN_LAST) begin
            sync_q <= 1'b1;
            run_q  <= '0;
            hist_q <= '0;
            win_q  <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          sr_q <= {sr_q[SR_W-2:0], pred};
          if (lose) begin
            sync_q <= 1'b0;
            fill_q <= '0;
            run_q  <= '0;
            hist_q <= '0;
            win_q  <= '0;
          end else begin
            hist_q <= {hist_q[WIN_LEN-2:0], mism};
            win_q  <= win_nxt;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (clr_cnt_i)
      cnt_q <= '0;
    else if (!restart && bit_vld_i && sync_q && mism && (cnt_q != CNT_MAX))
      cnt_q <= cnt_q + 1'b1;
  end

  assert_sync_off_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> !sync_o);

  assert_no_count_hunting_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && !clr_cnt_i) |=> $stable(err_cnt_o));

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_cnt_i |=> ((err_cnt_o == $past(err_cnt_o)) ||
                    (err_cnt_o == $past(err_cnt_o) + CNT_W'(1))));

  assert_saturate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_cnt_o == CNT_MAX) && !clr_cnt_i) |=> (err_cnt_o == CNT_MAX));

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cnt_i |=> (err_cnt_o == '0));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && !clr_cnt_i && det_en_i && $stable(seq15_sel_i))
      |=> ($stable(sync_o) && $stable(err_cnt_o)));

  assert_mode_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq15_sel_i != $past(seq15_sel_i)) |=> !sync_o);

endmodule

// File: tb/prbs_err_checker_tb_top.sv
module prbs_err_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_en = 1'b0;
  logic       sel15 = 1'b1;
  logic       clr = 1'b0;
  logic       vld = 1'b0;
  logic       bin = 1'b0;
  logic       sync;
  logic [7:0] cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] g = 20'h00001;

  always #2.5 clk = ~clk;

  prbs_err_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .det_en_i(det_en), .seq15_sel_i(sel15),
    .clr_cnt_i(clr), .bit_vld_i(vld), .bit_i(bin),
    .sync_o(sync), .err_cnt_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic c);
    @(negedge clk);
    vld = v; bin = b; clr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic flip, input logic c);
    logic nb;
    nb = sel15 ? (g[14] ^ g[13]) : (g[19] ^ g[16]);
    g = {g[18:0], nb};
    drive(1'b1, nb ^ flip, c);
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0);
  endtask

  task automatic restart_lock(input logic s, input string req);
    int len;
    len = s ? 15 : 20;
    @(negedge clk);
    det_en = 1'b0;
    sel15 = s;
    drive(1'b0, 1'b0, 1'b0);
    chk({req, " sync off while disabled"}, sync, 0);
    @(negedge clk);
    det_en = 1'b1;
    clean(len + 31);
    chk({req, " no sync one bit early"}, sync, 0);
    clean(1);
    chk({req, " sync after L+32 bits"}, sync, 1);
  endtask

  task automatic t_reset;
    chk("R11 reset sync", sync, 0);
    chk("R11 reset count", cnt, 0);
  endtask

  task automatic t_lock15;
    restart_lock(1'b1, "R2 R3 mode15");
  endtask

  task automatic t_count;
    int base;
    base = cnt;
    send(1'b1, 1'b0);
    chk("R5 single error", cnt, base + 1);
    clean(20); send(1'b1, 1'b0); clean(20); send(1'b1, 1'b0);
    chk("R5 spaced errors", cnt, base + 3);
    chk("R5 lock kept", sync, 1);
  endtask

  task automatic t_loss;
    int base;
    clean(70);
    base = cnt;
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0);
    chk("R8 five errors keep lock", sync, 1);
    chk("R8 five counted", cnt, base + 5);
    clean(70);
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0);
    chk("R8 lock before sixth", sync, 1);
    send(1'b1, 1'b0);
    chk("R8 sixth error drops lock", sync, 0);
    chk("R8 sixth error counted", cnt, base + 11);
    clean(15 + 31);
    chk("R8 relock not early", sync, 0);
    clean(1);
    chk("R8 relock after L+32", sync, 1);
  endtask

  task automatic t_idle;
    int base;
    base = cnt;
    for (int i = 0; i < 10; i++) drive(1'b0, i[0], 1'b0);
    chk("R9 sync held when idle", sync, 1);
    chk("R9 count held when idle", cnt, base);
    clean(40);
    chk("R9 stream resumes error-free", cnt, base);
  endtask

  task automatic t_clear;
    send(1'b1, 1'b1);
    chk("R7 clear wins over error", cnt, 0);
    send(1'b1, 1'b0);
    chk("R7 count after clear", cnt, 1);
    drive(1'b0, 1'b0, 1'b1);
    chk("R7 clear on idle cycle", cnt, 0);
  endtask

  task automatic t_hunt;
    int k;
    @(negedge clk);
    det_en = 1'b0;
    drive(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    det_en = 1'b1;
    clean(20);
    send(1'b1, 1'b0);
    clean(26);
    chk("R4 hunting error delays lock", sync, 0);
    chk("R4 hunting error not counted", cnt, 0);
    k = 0;
    while (!sync && k < 150) begin send(1'b0, 1'b0); k++; end
    chk("R4 lock after hunting error", sync, 1);
    chk("R4 count still zero", cnt, 0);
  endtask

  task automatic t_sat;
    for (int i = 0; i < 254; i++) begin clean(12); send(1'b1, 1'b0); end
    chk("R6 count 254", cnt, 254);
    clean(12); send(1'b1, 1'b0);
    chk("R6 count 255", cnt, 255);
    for (int i = 0; i < 5; i++) begin clean(12); send(1'b1, 1'b0); end
    chk("R6 saturated", cnt, 255);
    chk("R6 lock kept", sync, 1);
  endtask

  task automatic t_disable;
    int base;
    base = cnt;
    @(negedge clk);
    det_en = 1'b0;
    send(1'b0, 1'b0);
    chk("R1 sync off", sync, 0);
    for (int i = 0; i < 3; i++) send(1'b1, 1'b0);
    chk("R1 no counting disabled", cnt, base);
    chk("R1 count held", cnt, 255);
    restart_lock(1'b1, "R1 relock");
  endtask

  task automatic t_mode20;
    restart_lock(1'b0, "R2 R3 mode20");
    drive(1'b0, 1'b0, 1'b1);
    send(1'b1, 1'b0);
    chk("R3 mode20 error counted", cnt, 1);
    @(negedge clk);
    sel15 = 1'b1;
    send(1'b0, 1'b0);
    chk("R10 mode change drops lock", sync, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_lock15();
    t_count();
    t_loss();
    t_idle();
    t_clear();
    t_hunt();
    t_sat();
    t_disable();
    t_mode20();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule